// File: doc/BRIEF.md
# Power-Down Mode Clock Controller

This block produces the clock enables of a small microcontroller-style system from a single base clock. The CPU enable can run at the full rate or at one of five slower rates. A group of general peripherals gets one enable per module. A separate always-on enable feeds a watch-domain group made up of a watchdog channel and an infrared receiver. Software sets the speed ratio, the low-power mode to enter and the per-module stop bits through an 8-bit register bus.

A one-cycle sleep request from the CPU moves the block from its run state into the low-power state chosen by the mode field. Each low-power state turns off a different set of domains: sleep stops only the CPU, watch keeps only the watch group alive, and standby halts the divider and every enable. A wake event brings the block back to the run state. An external lock input blocks writes to the mode, speed and two of the four stop registers. Reads are never blocked.

Top module: `pwrClkCtrl`

## Requirements
- R1: After reset the registers read back as follows: mode 0x00 at 0xFF84, speed 0x00 at 0xFF85, stop-high 0x3F at 0xFF86, stop-low 0xFF at 0xFF87, stop-A 0xFC at 0xFE7E, stop-B 0xFF at 0xFE7F. Any other address reads 0x00.
- R2: While regLock is 1, writes to 0xFF84 to 0xFF87 are dropped and those registers read back unchanged. Writes to 0xFE7E and 0xFE7F still take effect. Reads always return the current value.
- R3: In the run state, cpuClkEn pulses once every 2^n cycles, where n is speed register bits [2:0] for values 0 to 5. Values 6 and 7 give the divide-by-32 period.
- R4: A new speed value takes effect only after the period in progress has completed. The first gap after a change therefore keeps the old length.
- R5: Sleep request with mode bits [1:0] = 00 enters sleep on the next cycle. In sleep, cpuClkEn is 0, watchClkEn is 1, and periphClkEn follows the stop mask.
- R6: Sleep request with mode bits [1:0] = 01 enters watch. In watch, cpuClkEn is 0, all periphClkEn bits are 0, and watchClkEn is 1.
- R7: Sleep request with mode bit [1] = 1 enters standby. In standby, cpuClkEn, divTick, watchClkEn and every periphClkEn bit are 0.
- R8: A wake event in any low-power state returns to the run state on the next cycle. A wake event in the run state has no effect. A sleep request in a low-power state is ignored.
- R9: In run and sleep, periphClkEn[i] is the inverse of stop bit i, with bits 7:0 from stop-low, 15:8 from stop-high, 23:16 from stop-B and 31:24 from stop-A. A stop bit of 1 stops that module. After reset periphClkEn reads 0x0300C000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Register address for reads and writes |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| regLock | input | 1 | When 1, blocks writes to the lockable registers |
| busRdData | output | 8 | Combinational read data for busAddr |
| sleepReq | input | 1 | One-cycle request to enter the selected low-power state |
| wakeEvt | input | 1 | Wake event that returns the block to run |
| cpuClkEn | output | 1 | CPU clock enable |
| divTick | output | 1 | Divided-rate tick, active unless in standby |
| watchClkEn | output | 1 | Enable for the watch-domain group |
| periphClkEn | output | 32 | Per-module peripheral clock enables |

## Verification
The hardest case to reach from the ports is a speed change written in the middle of a divided period. To detect a divider that switches early, the write must land at a known counter phase. The bench first waits for a CPU tick at divide-by-8. It then places the write so that it lands two counts into the period. It checks that the next tick still comes five cycles after the write completes, and that the following gap is two cycles. Low-power entry is also checked with a sleep request issued while already in watch, after the mode field has been changed to standby. Only the watch enable staying high shows that the request was ignored.

// File: rtl/pwrClkPkg.sv
package pwrClkPkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_WATCH   = 2'd2,
    ST_STANDBY = 2'd3
  } pwrState_e;

  // Domain strobes from control to datapath
  typedef struct packed {
    logic cpuRun;     // CPU enable may pass divider ticks
    logic periphRun;  // general peripherals may run
    logic watchRun;   // watch-domain group runs
    logic oscRun;     // divider and clock generator running
  } clkStrobes_t;

endpackage

// File: rtl/pwrCtrlFsm.sv
module pwrCtrlFsm
  import pwrClkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepReq,
  input  logic        wakeEvt,
  input  logic [1:0]  modeSel,
  output clkStrobes_t strobes
);

  pwrState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    if (state == ST_RUN) begin
      if (sleepReq) begin
        case (modeSel)
          2'b00:   stateNxt = ST_SLEEP;
          2'b01:   stateNxt = ST_WATCH;
          default: stateNxt = ST_STANDBY;
        endcase
      end
    end else if (wakeEvt) begin
      stateNxt = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    case (state)
      ST_RUN:     strobes = '{cpuRun: 1'b1, periphRun: 1'b1, watchRun: 1'b1, oscRun: 1'b1};
      ST_SLEEP:   strobes = '{cpuRun: 1'b0, periphRun: 1'b1, watchRun: 1'b1, oscRun: 1'b1};
      ST_WATCH:   strobes = '{cpuRun: 1'b0, periphRun: 1'b0, watchRun: 1'b1, oscRun: 1'b1};
      default:    strobes = '{cpuRun: 1'b0, periphRun: 1'b0, watchRun: 1'b0, oscRun: 1'b0};
    endcase
  end

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && sleepReq && modeSel == 2'b00) |=> state == ST_SLEEP); // R5
  AST_WATCH_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && sleepReq && modeSel == 2'b01) |=> state == ST_WATCH); // R6
  AST_STANDBY_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && sleepReq && modeSel[1]) |=> state == ST_STANDBY); // R7
  AST_WAKE_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_RUN && wakeEvt) |=> state == ST_RUN); // R8
  AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_RUN && !wakeEvt) |=> $stable(state)); // R8

endmodule

// File: rtl/pwrClkDatapath.sv
module pwrClkDatapath
  import pwrClkPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_REG   = 6,
  parameter int DIV_SEL_W = 3,
  parameter int MAX_SEL   = 5,
  // register order: 0 mode, 1 speed, 2 stop-high, 3 stop-low, 4 stop-A, 5 stop-B
  parameter logic [NUM_REG*ADDR_W-1:0] REG_ADDR =
    {16'hFE7F, 16'hFE7E, 16'hFF87, 16'hFF86, 16'hFF85, 16'hFF84},
  parameter logic [NUM_REG*DATA_W-1:0] REG_RST =
    {8'hFF, 8'hFC, 8'hFF, 8'h3F, 8'h00, 8'h00},
  parameter logic [NUM_REG-1:0] REG_LOCKABLE = 6'b001111,
  localparam int NUM_MOD = 4 * DATA_W,
  localparam int CNT_W   = MAX_SEL
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic                busWrEn,
  input  logic                regLock,
  output logic [DATA_W-1:0]   busRdData,
  input  clkStrobes_t         strobes,
  output logic [1:0]          modeSel,
  output logic                cpuClkEn,
  output logic                divTick,
  output logic                watchClkEn,
  output logic [NUM_MOD-1:0]  periphClkEn
);

  localparam int IDX_MODE = 0;
  localparam int IDX_SPD  = 1;
  localparam int IDX_HI   = 2;
  localparam int IDX_LO   = 3;
  localparam int IDX_A    = 4;
  localparam int IDX_B    = 5;

  logic [DATA_W-1:0]    regQ [NUM_REG];
  logic [NUM_REG-1:0]   wrHit;

  // write decode per register
  for (genvar g = 0; g < NUM_REG; g++) begin : gReg
    assign wrHit[g] = busWrEn
                   && (busAddr == REG_ADDR[g*ADDR_W +: ADDR_W])
                   && !(REG_LOCKABLE[g] && regLock);
    if (REG_LOCKABLE[g]) begin : gLockChk
      AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
        (busWrEn && regLock && busAddr == REG_ADDR[g*ADDR_W +: ADDR_W])
          |=> $stable(regQ[g])); // R2
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REG; i++) regQ[i] <= REG_RST[i*DATA_W +: DATA_W];
    end else begin
      for (int i = 0; i < NUM_REG; i++) if (wrHit[i]) regQ[i] <= busWrData;
    end
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_REG; i++)
      if (busAddr == REG_ADDR[i*ADDR_W +: ADDR_W]) busRdData = regQ[i];
  end

  // divider: ratio is sampled only at a wrap
  logic [DIV_SEL_W-1:0] rawSel, selClamp, activeSel;
  logic [CNT_W-1:0]     divCnt, divLimit;
  logic                 divWrap;

  assign rawSel   = regQ[IDX_SPD][DIV_SEL_W-1:0];
  assign selClamp = (rawSel > DIV_SEL_W'(MAX_SEL)) ? DIV_SEL_W'(MAX_SEL) : rawSel;
  assign divLimit = CNT_W'((32'd1 << activeSel) - 32'd1);
  assign divWrap  = (divCnt == divLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      activeSel <= '0;
    end else if (strobes.oscRun) begin
      if (divWrap) begin
        divCnt    <= '0;
        activeSel <= selClamp;
      end else begin
        divCnt    <= divCnt + 1'b1;
      end
    end
  end

  assign divTick     = strobes.oscRun && divWrap;
  assign cpuClkEn    = divTick && strobes.cpuRun;
  assign watchClkEn  = strobes.watchRun;
  assign modeSel     = regQ[IDX_MODE][1:0];
  assign periphClkEn = {NUM_MOD{strobes.periphRun}}
                     & ~{regQ[IDX_A], regQ[IDX_B], regQ[IDX_HI], regQ[IDX_LO]};

  AST_RATIO_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeSel) |-> $past(divTick)); // R4

endmodule

// File: rtl/pwrClkCtrl.sv
module pwrClkCtrl
  import pwrClkPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int NUM_MOD = 4 * DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               busWrEn,
  input  logic               regLock,
  output logic [DATA_W-1:0]  busRdData,
  input  logic               sleepReq,
  input  logic               wakeEvt,
  output logic               cpuClkEn,
  output logic               divTick,
  output logic               watchClkEn,
  output logic [NUM_MOD-1:0] periphClkEn
);

  clkStrobes_t strobes;
  logic [1:0]  modeSel;

  pwrCtrlFsm u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sleepReq (sleepReq),
    .wakeEvt  (wakeEvt),
    .modeSel  (modeSel),
    .strobes  (strobes)
  );

  pwrClkDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .busAddr     (busAddr),
    .busWrData   (busWrData),
    .busWrEn     (busWrEn),
    .regLock     (regLock),
    .busRdData   (busRdData),
    .strobes     (strobes),
    .modeSel     (modeSel),
    .cpuClkEn    (cpuClkEn),
    .divTick     (divTick),
    .watchClkEn  (watchClkEn),
    .periphClkEn (periphClkEn)
  );

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !watchClkEn |-> (periphClkEn == '0 && !divTick && !cpuClkEn)); // R7

endmodule

// File: tb/pwrClkCtrl_bench.sv
`timescale 1ns/1ps
module pwrClkCtrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWrEn = 1'b0;
  logic        regLock = 1'b0;
  logic [7:0]  busRdData;
  logic        sleepReq = 1'b0;
  logic        wakeEvt = 1'b0;
  logic        cpuClkEn, divTick, watchClkEn;
  logic [31:0] periphClkEn;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pwrClkCtrl u_pwrClkCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .regLock(regLock), .busRdData(busRdData),
    .sleepReq(sleepReq), .wakeEvt(wakeEvt), .cpuClkEn(cpuClkEn),
    .divTick(divTick), .watchClkEn(watchClkEn), .periphClkEn(periphClkEn)
  );

  // speed table: field value -> expected tick gap (R3)
  localparam int SPEED_SEL [8] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int SPEED_GAP [8] = '{1, 2, 4, 8, 16, 32, 32, 32};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    busAddr = a;
    #1;
    check(busRdData == exp, req, {24'd0, busRdData}, {24'd0, exp});
  endtask

  task automatic pulseSleep();
    @(negedge clk); sleepReq = 1'b1;
    @(negedge clk); sleepReq = 1'b0;
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeEvt = 1'b1;
    @(negedge clk); wakeEvt = 1'b0;
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!cpuClkEn);
  endtask

  task automatic gapToTick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!cpuClkEn && n < 100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rdCheck(16'hFF84, 8'h00, "R1 mode reset");
    rdCheck(16'hFF85, 8'h00, "R1 speed reset");
    rdCheck(16'hFF86, 8'h3F, "R1 stop-high reset");
    rdCheck(16'hFF87, 8'hFF, "R1 stop-low reset");
    rdCheck(16'hFE7E, 8'hFC, "R1 stop-A reset");
    rdCheck(16'hFE7F, 8'hFF, "R1 stop-B reset");
    rdCheck(16'h1234, 8'h00, "R1 unmapped read");
    check(periphClkEn == 32'h0300C000, "R9 reset enables", periphClkEn, 32'h0300C000);
    check(cpuClkEn && divTick && watchClkEn, "R3 run undivided after reset",
          {29'd0, cpuClkEn, divTick, watchClkEn}, 32'h7);

    // R3 table walk
    for (int i = 0; i < 8; i++) begin
      wrReg(16'hFF85, 8'(SPEED_SEL[i]));
      repeat (40) @(negedge clk);
      waitTick();
      gapToTick(gap);
      check(gap == SPEED_GAP[i], "R3 tick period", gap, SPEED_GAP[i]);
    end

    // R4 change mid-period: old period completes first
    wrReg(16'hFF85, 8'h03);
    repeat (40) @(negedge clk);
    waitTick();
    @(negedge clk);
    wrReg(16'hFF85, 8'h01);
    gapToTick(gap);
    check(gap == 5, "R4 old period completes", gap, 5);
    gapToTick(gap);
    check(gap == 2, "R4 new period after wrap", gap, 2);
    wrReg(16'hFF85, 8'h00);
    repeat (40) @(negedge clk);

    // R2 lock
    regLock = 1'b1;
    wrReg(16'hFF84, 8'h02);
    rdCheck(16'hFF84, 8'h00, "R2 locked mode write dropped");
    wrReg(16'hFF87, 8'h00);
    rdCheck(16'hFF87, 8'hFF, "R2 locked stop-low write dropped");
    wrReg(16'hFE7E, 8'h00);
    rdCheck(16'hFE7E, 8'h00, "R2 stop-A writable under lock");
    regLock = 1'b0;

    // R9 stop mapping
    wrReg(16'hFF87, 8'hF0);
    wrReg(16'hFF86, 8'h00);
    @(negedge clk);
    check(periphClkEn == 32'hFF00FF0F, "R9 stop mask mapping", periphClkEn, 32'hFF00FF0F);

    // R8 wake in run has no effect
    pulseWake();
    check(cpuClkEn && periphClkEn == 32'hFF00FF0F, "R8 wake ignored in run",
          {31'd0, cpuClkEn}, 32'h1);

    // R5 sleep
    wrReg(16'hFF84, 8'h00);
    pulseSleep();
    check(!cpuClkEn && watchClkEn && divTick, "R5 sleep cpu off",
          {29'd0, cpuClkEn, watchClkEn, divTick}, 32'h3);
    check(periphClkEn == 32'hFF00FF0F, "R5 sleep peripherals run", periphClkEn, 32'hFF00FF0F);
    repeat (3) @(negedge clk);
    check(!cpuClkEn, "R5 sleep holds", {31'd0, cpuClkEn}, 32'h0);
    pulseWake();
    check(cpuClkEn, "R8 wake from sleep", {31'd0, cpuClkEn}, 32'h1);

    // R6 watch
    wrReg(16'hFF84, 8'h01);
    pulseSleep();
    check(!cpuClkEn && watchClkEn && periphClkEn == 32'h0, "R6 watch domains",
          {31'd0, watchClkEn}, 32'h1);
    wrReg(16'hFF84, 8'h02);
    pulseSleep();
    check(watchClkEn && !cpuClkEn, "R8 sleep request ignored in watch",
          {30'd0, watchClkEn, cpuClkEn}, 32'h2);
    pulseWake();
    check(cpuClkEn && periphClkEn == 32'hFF00FF0F, "R8 wake from watch",
          periphClkEn, 32'hFF00FF0F);

    // R7 standby (mode 10 then 11)
    pulseSleep();
    check(!cpuClkEn && !divTick && !watchClkEn && periphClkEn == 32'h0, "R7 standby all off",
          {29'd0, cpuClkEn, divTick, watchClkEn}, 32'h0);
    repeat (5) @(negedge clk);
    check(!divTick, "R7 standby divider halted", {31'd0, divTick}, 32'h0);
    pulseWake();
    check(cpuClkEn && watchClkEn, "R8 wake from standby", {31'd0, cpuClkEn}, 32'h1);
    wrReg(16'hFF84, 8'h03);
    pulseSleep();
    check(!watchClkEn && !divTick, "R7 mode 11 enters standby",
          {30'd0, watchClkEn, divTick}, 32'h0);
    pulseWake();
    check(cpuClkEn, "R8 wake after mode 11", {31'd0, cpuClkEn}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule